// File: doc/BRIEF.md
# IOMMU Interrupt Delivery Unit

This block turns interrupt notifications raised inside an IOMMU-style device into either wired interrupt pulses or memory-write messages. It holds a small table of message vectors and a read-only array of queued-vector bits. Both sit at fixed offsets in the device register space and are reached through a little-endian register port that accepts 4-byte and 8-byte accesses. Each vector entry takes 16 bytes: a 64-bit target address, a 32-bit payload and one spare word.

A notify input carries a vector index. The level of `wired_sel`, which comes from the device's feature-control register, chooses the delivery path. When `wired_sel` is high, the interrupt line with the same index pulses for one cycle. When it is low, the vector is queued and a two-state machine sends it as one 32-bit write request. In `S_IDLE`, the machine takes the lowest queued vector, latches that vector's address and payload, clears its queued bit and moves to `S_SEND` (transition *issue*). In `S_SEND`, it holds `msi_valid` until `msi_ready` is seen and then returns to `S_IDLE` (transition *accept*). With no queued vector it stays in `S_IDLE` (*wait*), and with no ready it stays in `S_SEND` (*stall*).

Top module: `iommu_irq_deliver`

## Requirements
- R1: After reset, every table word reads zero, the queued-vector array reads zero, and `irq_o`, `msi_valid` and `err_o` are low.
- R2: The table starts at register offset `BASE` (default 0x300). Entry v occupies `BASE+16v`: +0 holds address bits 31:0, +4 holds address bits 63:32, +8 holds the payload and +12 holds a spare word. Each word can be written and read back with 4-byte accesses, and read data appears on `reg_rdata` with `reg_rvalid` one cycle after the request.
- R3: An 8-byte access (`reg_wide`=1) is aligned down to 8 bytes and acts as two 4-byte accesses. The word at the lower address maps to bits 31:0.
- R4: The queued-vector array is 8 bytes at `BASE+256`. Bit v of the first word is set while vector v is waiting to be sent, and the other bits read zero. Writes to the array are ignored.
- R5: An access at offsets 80 to 255 from `BASE` changes nothing, reads zero, and raises `err_o` for exactly one cycle starting one cycle after the request.
- R6: With `wired_sel`=1 and vector v below 4, `irq_o` equals one-hot v for exactly one cycle, starting one cycle after the notify. No message is sent and nothing is queued.
- R7: With `wired_sel`=0, a notify for vector v produces exactly one request with the address and payload of entry v. While `msi_ready` is low, `msi_valid`, `msi_addr` and `msi_data` stay unchanged.
- R8: Notifies that arrive while a request is outstanding are queued and issued in ascending vector order. A second notify for a vector that is already queued merges with the first.
- R9: A notify for vector 5 or above, or for vector 4 with `wired_sel`=1, is ignored and raises `err_o` for one cycle, starting one cycle after the notify.
- R10: A request's address and payload are taken when it is issued. Table writes made while the request is stalled do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_valid | input | 1 | Register access request |
| reg_write | input | 1 | 1 for a write, 0 for a read |
| reg_wide | input | 1 | 1 for an 8-byte access, 0 for a 4-byte access |
| reg_addr | input | 12 | Byte address within the device register space |
| reg_wdata | input | 64 | Write data (bits 31:0 for a 4-byte access) |
| reg_rdata | output | 64 | Read data, one cycle after the request |
| reg_rvalid | output | 1 | Read data valid |
| wired_sel | input | 1 | Selects wired delivery when high |
| notify_valid | input | 1 | Notification strobe |
| notify_vec | input | 3 | Notified vector index |
| irq_o | output | 4 | Wired interrupt lines |
| msi_valid | output | 1 | Message write request |
| msi_ready | input | 1 | Message write accepted |
| msi_addr | output | 64 | Message target address |
| msi_data | output | 32 | Message payload |
| err_o | output | 1 | One-cycle error flag |

## Verification
A corrupted queued-vector register shows up in two ways. The array readback at `BASE+256` has wrong bits in the same cycle, and requests then come out in the wrong order, come out twice, or never come out once the port is released. A state machine stuck in `S_SEND`, or leaving it without `msi_ready`, shows as a request held forever, or as a request whose fields change before acceptance, within one cycle of the stall. A wrong table word shows as a mismatched readback one cycle after the read, or as a wrong address or payload on the next request for that vector.

// File: rtl/ivd_pkg.sv
package ivd_pkg;
    typedef enum logic [0:0] {
        S_IDLE = 1'b0,
        S_SEND = 1'b1
    } ivd_state_e;

    typedef struct packed {
        logic [63:0] addr;
        logic [31:0] data;
    } ivd_msg_t;
endpackage

// File: rtl/ivd_vtable.sv
module ivd_vtable
    import ivd_pkg::*;
#(
    parameter int NVEC = 5,
    parameter int AW = 12,
    parameter logic [AW-1:0] BASE = 12'h300,
    localparam int VW = $clog2(NVEC)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            acc_valid,
    input  logic            acc_write,
    input  logic            acc_wide,
    input  logic [AW-1:0]   acc_addr,
    input  logic [63:0]     acc_wdata,
    input  logic [NVEC-1:0] pend,
    input  logic [VW-1:0]   rd_vec,
    output logic [63:0]     acc_rdata,
    output logic            acc_rvalid,
    output logic            acc_err,
    output ivd_msg_t        rd_msg
);
    localparam int TW = NVEC * 4;
    localparam int PBA_BYTES = ((NVEC + 63) / 64) * 8;
    localparam int PBA_W = PBA_BYTES / 4;
    localparam int WIW = AW - 2;
    localparam int PBA_WORD0 = 64;

    logic [31:0] words [TW];
    logic [AW:0] off;
    logic in_low, in_pba, tbl_hit, tbl_err_c;
    logic [WIW-1:0] wi0, wi1;
    logic [31:0] lo, hi;
    logic [PBA_BYTES*8-1:0] pba_ext;

    assign off = {1'b0, acc_addr} - {1'b0, BASE};
    assign in_low = !off[AW] && (off < (AW+1)'(256));
    assign in_pba = !off[AW] && (off >= (AW+1)'(256)) && (off < (AW+1)'(256 + PBA_BYTES));
    assign wi0 = {off[AW-1:3], off[2] & ~acc_wide};
    assign wi1 = {off[AW-1:3], 1'b1};
    assign tbl_hit = in_low && (int'(wi0) < TW);
    assign tbl_err_c = in_low && !tbl_hit;
    assign pba_ext = {{(PBA_BYTES*8-NVEC){1'b0}}, pend};

    always_comb begin
        lo = '0;
        hi = '0;
        for (int i = 0; i < TW; i++) begin
            if (tbl_hit && wi0 == WIW'(i)) lo = words[i];
            if (tbl_hit && acc_wide && wi1 == WIW'(i)) hi = words[i];
        end
        for (int j = 0; j < PBA_W; j++) begin
            if (in_pba && wi0 == WIW'(PBA_WORD0 + j)) lo = pba_ext[j*32 +: 32];
            if (in_pba && acc_wide && wi1 == WIW'(PBA_WORD0 + j)) hi = pba_ext[j*32 +: 32];
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < TW; i++) begin
            if (!rst_n) begin
                words[i] <= '0;
            end else if (acc_valid && acc_write && tbl_hit) begin
                if (wi0 == WIW'(i)) words[i] <= acc_wdata[31:0];
                if (acc_wide && wi1 == WIW'(i)) words[i] <= acc_wdata[63:32];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_rvalid <= 1'b0;
            acc_rdata  <= '0;
            acc_err    <= 1'b0;
        end else begin
            acc_rvalid <= acc_valid && !acc_write;
            acc_rdata  <= (acc_valid && !acc_write) ? {hi, lo} : 64'd0;
            acc_err    <= acc_valid && tbl_err_c;
        end
    end

    always_comb begin
        rd_msg = '0;
        for (int v = 0; v < NVEC; v++) begin
            if (rd_vec == VW'(v)) begin
                rd_msg.addr = {words[4*v+1], words[4*v]};
                rd_msg.data = words[4*v+2];
            end
        end
    end

    // R5: an access outside the table window never returns data
    p_err_read_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err |-> acc_rdata == 64'd0);
endmodule

// File: rtl/ivd_msi_fsm.sv
module ivd_msi_fsm
    import ivd_pkg::*;
#(
    parameter int NVEC = 5,
    localparam int VW = $clog2(NVEC)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            set_valid,
    input  logic [VW-1:0]   set_vec,
    input  ivd_msg_t        entry,
    input  logic            msi_ready,
    output logic [VW-1:0]   pick_vec,
    output logic [NVEC-1:0] pend_q,
    output logic            msi_valid,
    output logic [63:0]     msi_addr,
    output logic [31:0]     msi_data
);
    ivd_state_e state_q, state_d;
    ivd_msg_t msg_q;
    logic [NVEC-1:0] pend_d;
    logic any_pend, issue;

    always_comb begin
        pick_vec = '0;
        for (int v = NVEC - 1; v >= 0; v--) begin
            if (pend_q[v]) pick_vec = VW'(v);
        end
    end

    assign any_pend = |pend_q;
    assign issue = (state_q == S_IDLE) && any_pend;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (any_pend) state_d = S_SEND;
            S_SEND: if (msi_ready) state_d = S_IDLE;
        endcase
    end

    always_comb begin
        pend_d = pend_q;
        for (int v = 0; v < NVEC; v++) begin
            if (issue && pick_vec == VW'(v)) pend_d[v] = 1'b0;
            if (set_valid && set_vec == VW'(v)) pend_d[v] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            msg_q  <= '0;
        end else begin
            pend_q <= pend_d;
            if (issue) msg_q <= entry;
        end
    end

    always_comb begin
        msi_valid = (state_q == S_SEND);
        msi_addr  = msg_q.addr;
        msi_data  = msg_q.data;
    end

    // R7: a stalled request keeps its fields
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        msi_valid && !msi_ready |=> msi_valid && $stable(msi_addr) && $stable(msi_data));
    // R8: a notify during an outstanding request is queued
    p_queue_r8: assert property (@(posedge clk) disable iff (!rst_n)
        set_valid && state_q == S_SEND |=> pend_q[$past(set_vec)]);
endmodule

// File: rtl/iommu_irq_deliver.sv
module iommu_irq_deliver
    import ivd_pkg::*;
#(
    parameter int NVEC = 5,
    parameter int NLINE = 4,
    parameter int AW = 12,
    parameter logic [AW-1:0] BASE = 12'h300,
    localparam int VW = $clog2(NVEC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_valid,
    input  logic             reg_write,
    input  logic             reg_wide,
    input  logic [AW-1:0]    reg_addr,
    input  logic [63:0]      reg_wdata,
    output logic [63:0]      reg_rdata,
    output logic             reg_rvalid,
    input  logic             wired_sel,
    input  logic             notify_valid,
    input  logic [VW-1:0]    notify_vec,
    output logic [NLINE-1:0] irq_o,
    output logic             msi_valid,
    input  logic             msi_ready,
    output logic [63:0]      msi_addr,
    output logic [31:0]      msi_data,
    output logic             err_o
);
    logic [NVEC-1:0] pend;
    logic [VW-1:0] pick_vec;
    ivd_msg_t entry;
    logic tbl_err, vec_ok, line_ok, vec_err_q;
    logic [NLINE-1:0] irq_q, irq_d;

    assign vec_ok  = {1'b0, notify_vec} < (VW+1)'(NVEC);
    assign line_ok = {1'b0, notify_vec} < (VW+1)'(NLINE);

    ivd_vtable #(.NVEC(NVEC), .AW(AW), .BASE(BASE)) u_tbl (
        .clk(clk), .rst_n(rst_n),
        .acc_valid(reg_valid), .acc_write(reg_write), .acc_wide(reg_wide),
        .acc_addr(reg_addr), .acc_wdata(reg_wdata), .pend(pend),
        .rd_vec(pick_vec), .acc_rdata(reg_rdata), .acc_rvalid(reg_rvalid),
        .acc_err(tbl_err), .rd_msg(entry)
    );

    ivd_msi_fsm #(.NVEC(NVEC)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .set_valid(notify_valid && !wired_sel && vec_ok),
        .set_vec(notify_vec), .entry(entry), .msi_ready(msi_ready),
        .pick_vec(pick_vec), .pend_q(pend), .msi_valid(msi_valid),
        .msi_addr(msi_addr), .msi_data(msi_data)
    );

    always_comb begin
        for (int i = 0; i < NLINE; i++) begin
            irq_d[i] = notify_valid && wired_sel && (notify_vec == VW'(i));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q     <= '0;
            vec_err_q <= 1'b0;
        end else begin
            irq_q     <= irq_d;
            vec_err_q <= notify_valid && (wired_sel ? !line_ok : !vec_ok);
        end
    end

    assign irq_o = irq_q;
    assign err_o = tbl_err | vec_err_q;

    // R6: at most one wired line active
    p_irq_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_o));
    // R9: an out-of-range vector flags an error
    p_badvec_r9: assert property (@(posedge clk) disable iff (!rst_n)
        notify_valid && !vec_ok |=> err_o && irq_o == '0);
endmodule

// File: tb/sim_iommu_irq_deliver.sv
module sim_iommu_irq_deliver;
    localparam logic [11:0] BASE = 12'h300;

    logic clk = 0, rst_n = 0;
    logic reg_valid = 0, reg_write = 0, reg_wide = 0;
    logic [11:0] reg_addr = '0;
    logic [63:0] reg_wdata = '0, reg_rdata;
    logic reg_rvalid, wired_sel = 0, notify_valid = 0;
    logic [2:0] notify_vec = '0;
    logic [3:0] irq_o;
    logic msi_valid, msi_ready = 0, err_o;
    logic [63:0] msi_addr;
    logic [31:0] msi_data;

    int checks = 0, errors = 0;
    logic [31:0] sh [20];

    always #2 clk = ~clk;

    iommu_irq_deliver u0 (
        .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
        .reg_wide(reg_wide), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid), .wired_sel(wired_sel),
        .notify_valid(notify_valid), .notify_vec(notify_vec), .irq_o(irq_o),
        .msi_valid(msi_valid), .msi_ready(msi_ready), .msi_addr(msi_addr),
        .msi_data(msi_data), .err_o(err_o)
    );

    task automatic chk(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] ent(input int v, input int w);
        return BASE + 12'(16 * v + 4 * w);
    endfunction

    task automatic reg_wr(input logic [11:0] a, input logic wide, input logic [63:0] d);
        @(negedge clk);
        reg_valid = 1; reg_write = 1; reg_wide = wide; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_valid = 0; reg_write = 0;
    endtask

    task automatic reg_rd(input logic [11:0] a, input logic wide, output logic [63:0] d, output logic e);
        @(negedge clk);
        reg_valid = 1; reg_write = 0; reg_wide = wide; reg_addr = a;
        @(negedge clk);
        reg_valid = 0;
        d = reg_rdata;
        e = err_o;
        chk(reg_rvalid, "R2 rvalid", 96'(reg_rvalid), 96'd1);
    endtask

    task automatic notify(input int v, input logic wired, output logic [3:0] irq, output logic e);
        @(negedge clk);
        notify_valid = 1; notify_vec = 3'(v); wired_sel = wired;
        @(negedge clk);
        notify_valid = 0;
        irq = irq_o;
        e = err_o;
    endtask

    task automatic wait_msg(input int prob, output logic [63:0] a, output logic [31:0] d);
        logic seen = 0;
        logic [95:0] first = '0;
        a = '0; d = '0;
        for (int c = 0; c < 300; c++) begin
            @(negedge clk);
            msi_ready = ($urandom % 100) < prob;
            if (msi_valid && !seen) begin
                seen = 1;
                first = {msi_addr, msi_data};
            end
            if (msi_valid && msi_ready) begin
                a = msi_addr; d = msi_data;
                break;
            end
        end
        chk(seen, "R7 request seen", 96'(seen), 96'd1);
        chk({a, d} == first, "R7 fields held until accept", {a, d}, first);
        @(negedge clk);
        msi_ready = 0;
    endtask

    task automatic expect_msg(input int v, input int prob, input string req);
        logic [63:0] a; logic [31:0] d;
        wait_msg(prob, a, d);
        chk({a, d} == {sh[4*v+1], sh[4*v], sh[4*v+2]}, req, {a, d}, {sh[4*v+1], sh[4*v], sh[4*v+2]});
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] rd; logic e; logic [3:0] irq;
        int seed;
        seed = 11;
        void'($urandom(seed));
        for (int i = 0; i < 20; i++) sh[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        chk(irq_o == 0 && !msi_valid && !err_o, "R1 outputs idle", {irq_o, msi_valid, err_o}, 96'd0);
        reg_rd(ent(2, 2), 0, rd, e);
        chk(rd == 0, "R1 table zero", 96'(rd), 96'd0);
        reg_rd(BASE + 12'd256, 1, rd, e);
        chk(rd == 0, "R1 queue array zero", 96'(rd), 96'd0);

        // R2, R3 table fill
        for (int v = 0; v < 5; v++) begin
            logic [63:0] ad;
            ad = {$urandom, $urandom};
            sh[4*v] = ad[31:0]; sh[4*v+1] = ad[63:32];
            sh[4*v+2] = $urandom;
            reg_wr(ent(v, 0), 1, ad);
            reg_wr(ent(v, 2), 0, 64'(sh[4*v+2]));
        end
        reg_rd(ent(1, 2), 0, rd, e);
        chk(rd[31:0] == sh[6], "R2 payload word", 96'(rd), 96'(sh[6]));
        reg_wr(ent(4, 3), 0, 64'h5a5a_1234);
        sh[19] = 32'h5a5a_1234;
        reg_rd(ent(4, 3), 0, rd, e);
        chk(rd[31:0] == sh[19], "R2 spare word", 96'(rd), 96'(sh[19]));
        reg_rd(ent(3, 1), 1, rd, e);
        chk(rd == {sh[13], sh[12]}, "R3 wide read aligned down, low word first", 96'(rd), 96'({sh[13], sh[12]}));

        // R5 out of window
        reg_wr(BASE + 12'd80, 0, 64'hffff_ffff);
        chk(err_o == 1, "R5 write error flag", 96'(err_o), 96'd1);
        @(negedge clk);
        chk(err_o == 0, "R5 error one cycle", 96'(err_o), 96'd0);
        reg_rd(BASE + 12'd84, 0, rd, e);
        chk(rd == 0 && e, "R5 read zero with error", {rd, 31'd0, e}, 96'd1);
        reg_rd(ent(4, 0), 1, rd, e);
        chk(rd == {sh[17], sh[16]}, "R5 table untouched", 96'(rd), 96'({sh[17], sh[16]}));

        // R8, R4, R10 queue ordering
        msi_ready = 0;
        notify(3, 0, irq, e);
        notify(1, 0, irq, e);
        notify(4, 0, irq, e);
        notify(1, 0, irq, e);
        notify(0, 0, irq, e);
        reg_rd(BASE + 12'd256, 1, rd, e);
        chk(rd == 64'h13, "R4 queued bits", 96'(rd), 96'h13);
        reg_wr(BASE + 12'd256, 1, '1);
        reg_rd(BASE + 12'd256, 0, rd, e);
        chk(rd == 64'h13, "R4 write ignored", 96'(rd), 96'h13);
        begin
            logic [31:0] old2;
            old2 = sh[14];
            reg_wr(ent(3, 2), 0, 64'hdead_0003);
            expect_msg(3, 100, "R10 in-flight payload kept");
            sh[14] = 32'hdead_0003;
            chk(old2 != sh[14], "R10 new value differs", 96'(old2), 96'(sh[14]));
        end
        expect_msg(0, 60, "R8 order first queued 0");
        expect_msg(1, 60, "R8 order then 1");
        expect_msg(4, 60, "R8 order then 4");
        repeat (10) begin
            @(negedge clk);
            chk(!msi_valid, "R8 merged notify sends once", 96'(msi_valid), 96'd0);
        end
        notify(3, 0, irq, e);
        expect_msg(3, 100, "R10 new payload used");

        // R9 bad vectors
        notify(4, 1, irq, e);
        chk(e && irq == 0, "R9 vector 4 wired", {irq, e}, 96'd1);
        notify(6, 0, irq, e);
        chk(e && irq == 0, "R9 vector 6 message", {irq, e}, 96'd1);
        repeat (3) @(negedge clk);
        chk(!msi_valid, "R9 nothing sent", 96'(msi_valid), 96'd0);

        // random mix
        for (int it = 0; it < 60; it++) begin
            int op, v;
            op = $urandom % 4;
            v = $urandom % 5;
            if (op == 0) begin
                int w;
                w = $urandom % 4;
                sh[4*v+w] = $urandom;
                reg_wr(ent(v, w), 0, 64'(sh[4*v+w]));
                reg_rd(ent(v, w), 0, rd, e);
                chk(rd[31:0] == sh[4*v+w] && !e, "R2 random readback", 96'(rd), 96'(sh[4*v+w]));
            end else if (op == 1) begin
                notify(v, 0, irq, e);
                chk(irq == 0 && !e, "R7 message mode no wired pulse", {irq, e}, 96'd0);
                expect_msg(v, 30 + ($urandom % 70), "R7 message content");
            end else if (op == 2) begin
                v = v % 4;
                notify(v, 1, irq, e);
                chk(irq == 4'(1 << v) && !e, "R6 wired pulse", 96'(irq), 96'(1 << v));
                @(negedge clk);
                chk(irq_o == 0 && !msi_valid, "R6 pulse one cycle, no message", {irq_o, msi_valid}, 96'd0);
            end else begin
                notify(5 + ($urandom % 3), 0, irq, e);
                chk(e, "R9 random bad vector", 96'(e), 96'd1);
                @(negedge clk);
                chk(!err_o && !msi_valid, "R9 flag one cycle", {err_o, msi_valid}, 96'd0);
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule